// File: doc/BRIEF.md
# Power-Up Reset and Command Gate

This controller sits on the host side of a display controller. While the board powers up it holds the device's active-low reset. It releases that reset only when three things are true: every supply rail reports good, the park (power-good) input is high, and the reference clock is flagged stable. After release it watches the device's busy line, which the device drives high while it initialises itself and drops when it is ready.

Commands come in two classes. A standard command may go out at the earlier of two events: the device reports init-done, or a timeout counted from reset release expires. A compound command waits for init-done alone and has no timeout, because initialisation can last several seconds in some configurations.

Each class has a request/acknowledge pair. A request made while its gate is shut is held. It is acknowledged once, in the first cycle its gate is open. The bus that then carries the command lies outside this block.

Top module: `pwrup_cmd_gate`

## Requirements
- R1: `dev_rst_n` is 0 while `rst_n` is low. It also stays 0 while any of `rail_good`, `park_ok` or `refclk_ok` reads low after its two-flop synchroniser.
- R2: When the last of the power conditions becomes true, `dev_rst_n` rises at the third rising clock edge after it. At that same edge `status[1:0]` becomes 1 (waiting for init).
- R3: If any power condition drops while out of reset, `dev_rst_n` falls at the third rising edge. At that edge `status` becomes 0 and every held request is discarded. Requests made while `status[1:0]` is 0 are dropped, not held.
- R4: Init-done is recognised only after `dev_busy` has read high at least once since reset release. A low `dev_busy` before that has no effect.
- R5: If init-done has not arrived, the standard gate opens by timeout. `status[1:0]` becomes 2 and `status[2]` becomes 1 exactly `STD_TMO_MS*CYC_PER_MS+1` cycles after the first cycle with `dev_rst_n` high.
- R6: `cmp_ack` is never 1 before init-done. While `status[1:0]` is 2 the state is held until init-done; no timer ends it.
- R7: A fall of `dev_busy` is recognised as init-done. `status[1:0]` becomes 3 at the third rising edge after the fall. If this happens no later than the timeout would, the state goes straight from 1 to 3 and `status[2]` stays 0.
- R8: A request made in a cycle when its gate is open is acknowledged in that same cycle, for that cycle only.
- R9: A request made while its gate is shut is held. It is acknowledged exactly once, in the first cycle the gate is open.
- R10: `status[1:0]` encodes the state: 0 reset held, 1 waiting for init, 2 standard commands open, 3 all commands open. `status[2]` is a sticky flag that is 1 when the timeout, rather than init-done, opened the standard gate. The flag clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| rail_good | input | N_RAIL | Per-rail supply-good flags |
| park_ok | input | 1 | Park / power-good input |
| refclk_ok | input | 1 | Reference clock stable flag |
| dev_busy | input | 1 | Device busy line; high while the device initialises |
| std_req | input | 1 | Standard command request pulse |
| cmp_req | input | 1 | Compound command request pulse |
| dev_rst_n | output | 1 | Active-low reset to the device |
| std_ack | output | 1 | Standard command acknowledge |
| cmp_ack | output | 1 | Compound command acknowledge |
| status | output | 3 | {timeout flag, state[1:0]} |

## Verification
Every input that is sampled for the state takes three rising edges to reach the outputs: two synchroniser flops and then the state register. Reset release, reset reassertion and the init-done transition are therefore each checked one cycle before and in the cycle they fall due. The timeout lands `STD_TMO_MS*CYC_PER_MS+1` cycles after the first released cycle, with the timer scaled down. The bench compares the status against a per-cycle schedule derived from these counts, so an early or late transition shows up at once.

The acknowledges are combinational on the current state. They are sampled a moment after each request is driven, in the same cycle, and compared with a small model of the held requests.

// File: rtl/pwrup_cmd_gate.sv
module pwrup_cmd_gate #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int CYC_PER_MS = CLK_HZ / 1000,
  parameter int STD_TMO_MS = 100,
  parameter int N_RAIL     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RAIL-1:0] rail_good,
  input  logic              park_ok,
  input  logic              refclk_ok,
  input  logic              dev_busy,
  input  logic              std_req,
  input  logic              cmp_req,
  output logic              dev_rst_n,
  output logic              std_ack,
  output logic              cmp_ack,
  output logic [2:0]        status
);

  localparam int SW = N_RAIL + 3;
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MW = $clog2(STD_TMO_MS + 1);

  typedef enum logic [1:0] {S_RESET = 2'd0, S_WAIT = 2'd1, S_STD = 2'd2, S_ALL = 2'd3} st_t;

  logic [SW-1:0] sync1, sync2;
  logic          pwr_ok_s, bsy_s;
  st_t           state, nxt;
  logic [CW-1:0] cyc;
  logic [MW-1:0] ms;
  logic          tmo, seen, done;
  logic          via_tmo, rst_q;
  logic          std_pend, cmp_pend;
  logic          std_open, cmp_open;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {dev_busy, refclk_ok, park_ok, rail_good};
      sync2 <= sync1;
    end

  assign pwr_ok_s = &sync2[N_RAIL+1:0];
  assign bsy_s    = sync2[N_RAIL+2];

  assign tmo  = (ms == MW'(STD_TMO_MS));
  assign done = seen & ~bsy_s;

  always_comb begin
    nxt = state;
    case (state)
      S_RESET: if (pwr_ok_s) nxt = S_WAIT;
      S_WAIT:  if (done) nxt = S_ALL; else if (tmo) nxt = S_STD;
      S_STD:   if (done) nxt = S_ALL;
      default: nxt = state;
    endcase
    if (!pwr_ok_s) nxt = S_RESET;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_RESET;
      rst_q   <= 1'b0;
      via_tmo <= 1'b0;
      seen    <= 1'b0;
    end else begin
      state <= nxt;
      rst_q <= (nxt != S_RESET);
      if (nxt == S_RESET) via_tmo <= 1'b0;
      else if (state == S_WAIT && nxt == S_STD) via_tmo <= 1'b1;
      seen <= (state != S_RESET && nxt != S_RESET) ? (seen | bsy_s) : 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cyc <= '0;
      ms  <= '0;
    end else if (state != S_WAIT) begin
      cyc <= '0;
      ms  <= '0;
    end else if (!tmo) begin
      if (cyc == CW'(CYC_PER_MS - 1)) begin
        cyc <= '0;
        ms  <= ms + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end

  assign std_open = (state == S_STD) || (state == S_ALL);
  assign cmp_open = (state == S_ALL);
  assign std_ack  = std_open & (std_req | std_pend);
  assign cmp_ack  = cmp_open & (cmp_req | cmp_pend);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      std_pend <= 1'b0;
      cmp_pend <= 1'b0;
    end else if (state == S_RESET || nxt == S_RESET) begin
      std_pend <= 1'b0;
      cmp_pend <= 1'b0;
    end else begin
      std_pend <= (std_pend | std_req) & ~std_ack;
      cmp_pend <= (cmp_pend | cmp_req) & ~cmp_ack;
    end

  assign dev_rst_n = rst_q;
  assign status    = {via_tmo, state};

  a_r1_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_s |=> !dev_rst_n);

  a_r2_release_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> $past(pwr_ok_s));

  a_r3_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RESET) |-> (!std_pend && !cmp_pend && !status[2]));

  a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STD) |-> status[2]);

  a_r6_cmp_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ack |-> (seen && state == S_ALL));

  a_r7_no_backstep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ALL) |=> (state == S_ALL || state == S_RESET));

  a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (std_ack && !std_req) |=> !std_pend);

endmodule

// File: tb/pwrup_cmd_gate_tb.sv
module pwrup_cmd_gate_tb;
  localparam int CPM  = 5;
  localparam int TMO  = 4;
  localparam int NR   = 3;
  localparam int TCYC = TMO * CPM + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR+1:0] pwr = '0;
  logic busy = 1'b0, sreq = 1'b0, creq = 1'b0;
  logic dev_rst_n, std_ack, cmp_ack;
  logic [2:0] status;
  int nchk = 0, nfail = 0;
  bit sp_m = 0, cp_m = 0;

  always #10 clk = ~clk;

  pwrup_cmd_gate #(.CLK_HZ(50_000_000), .CYC_PER_MS(CPM), .STD_TMO_MS(TMO), .N_RAIL(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_good(pwr[NR-1:0]), .park_ok(pwr[NR]), .refclk_ok(pwr[NR+1]),
    .dev_busy(busy), .std_req(sreq), .cmp_req(creq),
    .dev_rst_n(dev_rst_n), .std_ack(std_ack), .cmp_ack(cmp_ack), .status(status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_status(input int c, input int d);
    int all_at = d + 3;
    if (c >= all_at) return (all_at > TCYC) ? 7 : 3;
    if (c >= TCYC) return 6;
    return 1;
  endfunction

  task automatic power_up(input int last);
    for (int i = 0; i < NR + 2; i++)
      if (i != last) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        pwr[i] = 1'b1;
        @(negedge clk);
        chk(dev_rst_n == 1'b0, "R1 partial power", dev_rst_n, 0);
      end
    @(negedge clk);
    pwr[last] = 1'b1;
    repeat (2) @(negedge clk);
    chk(dev_rst_n == 1'b0, "R2 release not early", dev_rst_n, 0);
    @(negedge clk);
    chk(dev_rst_n == 1'b1, "R2 release", dev_rst_n, 1);
    chk(status == 3'd1, "R2 status wait", status, 1);
  endtask

  task automatic power_drop(input int which);
    pwr[which] = 1'b0;
    repeat (2) @(negedge clk);
    chk(dev_rst_n == 1'b1, "R3 drop not early", dev_rst_n, 1);
    @(negedge clk);
    chk(dev_rst_n == 1'b0, "R3 reset reasserted", dev_rst_n, 0);
    chk(status == 3'd0, "R3 status cleared", status, 0);
    sp_m = 0;
    cp_m = 0;
    busy = 1'b0;
    pwr = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int r, input int d, input int abort, input bit force_req);
    int lim;
    bit so, co, es, ec;
    power_up($urandom_range(0, NR + 1));
    lim = ((d + 3 > TCYC) ? d + 3 : TCYC) + 3;
    if (abort >= 0) lim = abort;
    for (int c = 0; c < lim; c++) begin
      int e;
      if (c > 0) @(negedge clk);
      busy = (c >= r) && (c < d);
      sreq = ($urandom_range(0, 9) < 3) || (force_req && c == 1);
      creq = ($urandom_range(0, 9) < 3);
      #1;
      e = exp_status(c, d);
      chk(status == 3'(e), "R10 status schedule (R4 R5 R6 R7)", status, e);
      so = (e[1:0] >= 2);
      co = (e[1:0] == 3);
      es = so && (sreq || sp_m);
      ec = co && (creq || cp_m);
      chk(std_ack == es, sp_m ? "R9 held std ack" : "R8 std ack", std_ack, es);
      chk(cmp_ack == ec, cp_m ? "R9 held cmp ack (R6)" : "R8 cmp ack (R6)", cmp_ack, ec);
      sp_m = (sp_m || sreq) && !es;
      cp_m = (cp_m || creq) && !ec;
    end
    @(negedge clk);
    sreq = 1'b0;
    creq = 1'b0;
    power_drop($urandom_range(0, NR + 1));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(dev_rst_n == 1'b0, "R1 reset state", dev_rst_n, 0);
    chk(status == 3'd0, "R10 reset status", status, 0);
    chk(std_ack == 1'b0 && cmp_ack == 1'b0, "R1 no ack in reset", std_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sreq = 1'b1;
    creq = 1'b1;
    #1;
    chk(std_ack == 1'b0 && cmp_ack == 1'b0, "R3 request in reset dropped", cmp_ack, 0);
    @(negedge clk);
    sreq = 1'b0;
    creq = 1'b0;
    run(0, 30, -1, 1'b0);
    run(0, 18, -1, 1'b0);
    run(0, 19, -1, 1'b0);
    run(8, 12, -1, 1'b0);
    run(0, 40, 10, 1'b1);
    run(2, 6, -1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      int r = $urandom_range(0, 8);
      run(r, $urandom_range(r + 1, 34), -1, 1'b0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule